// File: doc/BRIEF.md
# Four-beat burst address sequencer

This block produces the array address for every cycle of a four-beat memory burst. When a burst begins, it captures a full external address. After that, each advance request moves the two lowest address bits to the next beat, while the upper bits stay at the captured value. Once four beats have been issued, the sequence wraps back to the first beat. The next beat is chosen from one of two orders, selected by a static mode pin:

- **Linear order:** the beat number is added to the start, modulo four.
- **Interleaved order:** the start is XORed with the beat number.

A burst can be started by either of two active-low strobes:

- **Processor strobe:** takes effect only while the chip-enable qualifier is low.
- **Controller strobe:** needs no enable, but yields to the processor strobe.

While neither strobe takes effect, the advance input either steps the sequence or suspends it. The block holds the start address and a two-bit beat count. It forms the low address bits from these two values and the mode pin. Because no register sits on the mode pin, a change of mode shows on the output in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after its release before any load, `arr_addr` is 0.
- R2: A rising clock edge with `strb_proc_n` = 0 and `cen_n` = 0 loads `ext_addr`. From the next cycle on, `arr_addr` equals that value.
- R3: A rising clock edge with `strb_proc_n` = 1 and `strb_ctrl_n` = 0 loads `ext_addr`, whatever the value of `cen_n`.
- R4: With `strb_proc_n` = 0 and `cen_n` = 1, the processor strobe has no effect. If `strb_ctrl_n` = 1, the edge behaves as if no strobe were active (R6, R7, R9 apply). If `strb_ctrl_n` = 0, the address holds.
- R5: On an edge that loads, `adv_n` has no effect. The loaded address appears unchanged.
- R6: With `order_sel` = 0, each edge with no load, `strb_ctrl_n` = 1 and `adv_n` = 0 moves the low two bits to start + n mod 4, where n is the beat number.
- R7: With `order_sel` = 1, the low two bits of beat n equal the start bits XOR n.
- R8: After the fourth beat, the next advance returns to the burst's first address.
- R9: With no strobe taking effect and `adv_n` = 1, `arr_addr` holds.
- R10: Bits 15..2 of `arr_addr` change only on an edge that loads.
- R11: `order_sel` acts combinationally. Changing it alters `arr_addr` in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strb_proc_n | input | 1 | Processor burst-start strobe, active low, qualified by `cen_n` |
| strb_ctrl_n | input | 1 | Controller burst-start strobe, active low |
| cen_n | input | 1 | Chip-enable qualifier for the processor strobe, active low |
| adv_n | input | 1 | Advance request, active low; high suspends |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| ext_addr | input | 16 | External start address |
| arr_addr | output | 16 | Current array address |

## Verification
The assertions check the following on every cycle:

- Each load delivers the external address, whatever the advance input is doing.
- The upper bits hold between loads.
- A suspended cycle keeps the address.
- A linear step adds one to the low bits.
- An interleaved step always flips bit 0.

Some behaviours depend on the whole burst history, not on a single step, so only the bench scenarios can show them:

- The full interleaved sequence.
- The wrap back to the first beat.
- The blocked processor strobe with and without the controller strobe.
- The same-cycle effect of the mode pin.
- Reset in the middle of a burst.

The bench's reference model covers these and long random runs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } seq_act_e;

endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
  import burst_seq_pkg::*;
(
  input  logic     strb_proc_n,
  input  logic     strb_ctrl_n,
  input  logic     cen_n,
  input  logic     adv_n,
  output seq_act_e act
);

  logic proc_take;
  logic ctrl_take;

  // The processor strobe needs the enable; the controller strobe yields to it.
  assign proc_take = ~strb_proc_n & ~cen_n;
  assign ctrl_take = strb_proc_n & ~strb_ctrl_n;

  always_comb begin
    act = ACT_HOLD;
    if (proc_take || ctrl_take) begin
      act = ACT_LOAD;
    end else if (strb_ctrl_n && !adv_n) begin
      act = ACT_STEP;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_act_e          act,
  output logic [BEAT_W-1:0] beat
);

  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  always_comb begin
    beat_en = 1'b0;
    beat_d  = beat;
    case (act)
      ACT_LOAD: begin beat_en = 1'b1; beat_d = '0;        end
      ACT_STEP: begin beat_en = 1'b1; beat_d = beat + 1'b1; end
      default:  begin beat_en = 1'b0; beat_d = beat;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (beat_en) begin
      beat <= beat_d;
    end
  end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // Linear: modular add, carry out of the top bit dropped.
  assign lin_low = start + beat;

  // Interleaved: each bit flips independently.
  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_low[i] = start[i] ^ beat[i];
  end

  assign low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              cen_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] arr_addr
);

  localparam int HI_W = ADDR_W - BEAT_W;

  seq_act_e          act;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] low;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  burst_strobe_decode u_dec (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .cen_n       (cen_n),
    .adv_n       (adv_n),
    .act         (act)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .beat  (beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (act == ACT_LOAD),
    .d       (ext_addr),
    .q       (base)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start (base[BEAT_W-1:0]),
    .beat  (beat),
    .order (order),
    .low   (low)
  );

  assign arr_addr = {base[ADDR_W-1 -: HI_W], low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb_proc_n,
  input logic              strb_ctrl_n,
  input logic              cen_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] arr_addr
);

  logic ld_p;
  logic ld_c;
  logic mv;
  logic idle;

  assign ld_p = !strb_proc_n && !cen_n;
  assign ld_c = strb_proc_n && !strb_ctrl_n;
  assign mv   = !ld_p && !ld_c && strb_ctrl_n && !adv_n;
  assign idle = !ld_p && !ld_c && !mv;

  a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_p |=> arr_addr == $past(ext_addr));

  a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_c |=> arr_addr == $past(ext_addr));

  a_r5_load_over_adv: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_p || ld_c) && !adv_n) |=> arr_addr == $past(ext_addr));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(arr_addr) || (order_sel != $past(order_sel))));

  a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_p || ld_c) |=> $stable(arr_addr[ADDR_W-1:BEAT_W]));

  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mv && !order_sel) |=>
      (order_sel || (arr_addr[BEAT_W-1:0] == $past(arr_addr[BEAT_W-1:0]) + 1'b1)));

  a_r7_inter_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mv && order_sel) |=> (!order_sel || (arr_addr[0] != $past(arr_addr[0]))));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strb_proc_n, strb_ctrl_n, cen_n, adv_n, order_sel;
  logic [15:0] ext_addr;
  logic [15:0] arr_addr;

  int checks = 0;
  int errors = 0;
  int m_base = 0;
  int m_beat = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .cen_n(cen_n), .adv_n(adv_n), .order_sel(order_sel), .ext_addr(ext_addr),
    .arr_addr(arr_addr)
  );

  function automatic int expect_addr();
    int s = m_base % 4;
    int lo;
    if (order_sel) lo = s ^ m_beat;
    else           lo = (s + m_beat) % 4;
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic compare(input string tag);
    int exp = expect_addr();
    checks++;
    if (int'(arr_addr) != exp) begin
      errors++;
      $display("FAIL %s: arr_addr=%h expected=%h", tag, arr_addr, exp[15:0]);
    end
  endtask

  task automatic cyc(input logic p, input logic c, input logic e, input logic a,
                     input logic md, input logic [15:0] ad, input string tag);
    bit ld, st;
    strb_proc_n = p; strb_ctrl_n = c; cen_n = e; adv_n = a; order_sel = md; ext_addr = ad;
    @(posedge clk);
    ld = (!p && !e) || (p && !c);
    st = !ld && c && !a;
    if (ld) begin m_base = int'(ad); m_beat = 0; end
    else if (st) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; cen_n = 1'b0;
    adv_n = 1'b1; order_sel = 1'b0; ext_addr = 16'h0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // Linear burst from low bits 01, then wrap
    cyc(0, 1, 0, 1, 0, 16'h1235, "R2");
    cyc(1, 1, 0, 0, 0, 16'h0000, "R6");
    cyc(1, 1, 0, 0, 0, 16'h0000, "R6");
    cyc(1, 1, 0, 0, 0, 16'h0000, "R6");
    cyc(1, 1, 0, 0, 0, 16'h0000, "R8");
    cyc(1, 1, 0, 1, 0, 16'hFFFF, "R9");
    cyc(1, 1, 1, 1, 0, 16'hFFFF, "R9");

    // Controller strobe with enable high; mode flip mid-burst
    cyc(1, 0, 1, 1, 0, 16'h4441, "R3");
    cyc(1, 1, 0, 0, 0, 16'h0000, "R6");
    order_sel = 1'b1; #1;
    compare("R11");
    order_sel = 1'b0; #1;
    compare("R11");

    // Interleaved burst from 10, then wrap
    cyc(0, 1, 0, 1, 1, 16'hABCE, "R2");
    cyc(1, 1, 0, 0, 1, 16'h0000, "R7");
    cyc(1, 1, 0, 0, 1, 16'h0000, "R7");
    cyc(1, 1, 0, 0, 1, 16'h0000, "R7");
    cyc(1, 1, 0, 0, 1, 16'h0000, "R8");

    // Load wins over advance
    cyc(0, 1, 0, 0, 0, 16'h0F03, "R5");
    cyc(1, 0, 0, 0, 0, 16'h7772, "R5");
    // Blocked processor strobe
    cyc(0, 1, 1, 0, 0, 16'hFFFF, "R4");
    cyc(0, 0, 1, 0, 0, 16'hFFFF, "R4");
    cyc(0, 1, 1, 1, 0, 16'hFFFF, "R4");

    // Reset mid-burst
    rst_n = 1'b0; #1;
    m_base = 0; m_beat = 0;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // Random traffic, upper bits tracked by the model
    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 3) == 0,
          ($urandom % 3) == 0, (i / 50) % 2 == 1, 16'($urandom), "R10");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule